// File: doc/BRIEF.md
# Two-Way Secondary Cache Tag Controller

This block holds the tags of a 256 KB secondary cache with 32-byte lines. The cache serves a processor bus with 32-bit addresses and 64-bit data. The cache is two-way set associative with 4096 sets. For each set, one internal tag word holds both way tags and one shared replacement bit. The two valid bits and the two dirty bits for the set are kept in a small array beside that word. A single synchronous read fetches all of this state, and at most one write updates it per transaction.

The processor side presents a request with an address and a write flag. The block looks up the set and reports hit or miss.

- **Read hit:** the block drives four data-bank beats. The first beat goes to the bank that holds the requested doubleword, and the rest follow in wrap order.
- **Read miss:** the block evicts the least-recently-used way. If that victim is dirty, it first asks the memory port to write it back. It then asks the memory port for a line fill and streams the new line in the same beat order.
- **Write hit:** the block issues one bank write beat and marks the line dirty.
- **Write miss:** the block does not allocate a line.

The processor is held off for the whole transaction. The data RAM and the DRAM side sit outside the block and use request/acknowledge ports.

Top module: `l2_tag_ctrl`

## Requirements
- R1: After reset is released, `cpu_ready` stays low for exactly SETS cycles while every set is cleared, and then rises. After this sweep every way is invalid and the replacement bit of every set points at way 0, including lines that were cached before the reset.
- R2: The address is split as follows: bits [4:0] are the byte in the line, bits [OFF_W+IDX_W-1:OFF_W] are the set (bits 16:5 by default), and the bits above are the tag. `bank_set` carries the set of the request during every bank beat.
- R3: A read hit reports `rsp_hit`=1 and then drives four `bank_rd` beats. The first `bank_sel` equals address bits [4:3], and each later beat adds 1 modulo 4 (for example 2, 3, 0, 1). A beat advances only on a cycle where `bank_ack` is high; otherwise `bank_sel` holds.
- R4: A hit on way w sets the replacement bit of the set to the other way. The next miss in that set therefore fills the way that was not just used.
- R5: A read miss asks the memory port for a fill with `mem_wr`=0 and a `mem_addr` that is line aligned: the request tag and set, with bits [4:0] zero. Once `mem_ack` arrives, the new line is streamed in R3 order.
- R6: A miss selects as victim the way named by the replacement bit. After the fill, the replacement bit names the other way. `bank_way` carries the way being accessed.
- R7: If the victim is valid and dirty, a write-back request (`mem_wr`=1, `mem_addr` = the stored victim tag with the same set and a zero offset) comes before the fill. Each memory request holds its address and its kind until it is acknowledged.
- R8: A write hit reports `rsp_hit`=1 and drives exactly one `bank_wr` beat with `bank_sel` equal to address bits [4:3] and the hit way. It marks that way dirty and updates the replacement bit as in R4.
- R9: A write miss reports `rsp_hit`=0. It makes no memory request and no bank beat, and it does not allocate: a later read of that line still misses.
- R10: `rsp_valid` pulses exactly once per request, and `cpu_ready` is low from acceptance until the transaction ends. While `cpu_ready` is high, there is no memory request and no bank beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request; accepted on a cycle where `cpu_ready` is high |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W (32) | Request byte address |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle lookup result strobe |
| rsp_hit | output | 1 | Lookup result, valid with `rsp_valid` |
| bank_rd | output | 1 | Data-bank read beat pending |
| bank_wr | output | 1 | Data-bank write beat pending |
| bank_sel | output | BEAT_W (2) | Bank (doubleword within the line) of the current beat |
| bank_set | output | IDX_W (12) | Set index for the data RAM |
| bank_way | output | 1 | Way for the data RAM |
| bank_ack | input | 1 | Bank beat accepted this cycle |
| mem_req | output | 1 | Memory line request pending |
| mem_wr | output | 1 | 1 = write-back of victim, 0 = line fill |
| mem_addr | output | ADDR_W (32) | Line-aligned memory address |
| mem_ack | input | 1 | Memory request complete |

## Verification
A corrupted tag word or flag shows up in the very next access to that set. It appears as a wrong `rsp_hit`, a wrong `bank_way`, or an unexpected write-back address, within two cycles of acceptance. A replacement bit that was updated wrongly stays hidden until the following miss in that set, so the bench touches each set with three or more competing tags. A failed clear sweep shows up as a hit on the first access after reset. A slip in the beat order shows on `bank_sel` at the first stalled beat.

// File: rtl/l2t_pkg.sv
package l2t_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_STREAM,
    ST_WBEAT
  } l2t_state_e;

  // Flag word layout per set: [1:0] valid per way, [3:2] dirty per way.
  localparam int FLAG_W = 4;

endpackage

// File: rtl/l2t_tag_store.sv
module l2t_tag_store #(
  parameter int SETS   = 4096,
  parameter int TAG_W  = 15,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WORD_W = 2 * TAG_W + 1
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [WORD_W-1:0]       wr_word,
  input  logic [l2t_pkg::FLAG_W-1:0] wr_flags,
  output logic [WORD_W-1:0]       rd_word,
  output logic [l2t_pkg::FLAG_W-1:0] rd_flags
);

  logic [WORD_W-1:0]          word_mem [SETS];
  logic [l2t_pkg::FLAG_W-1:0] flag_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      word_mem[wr_idx] <= wr_word;
      flag_mem[wr_idx] <= wr_flags;
    end
    if (rd_en) begin
      rd_word  <= word_mem[rd_idx];
      rd_flags <= flag_mem[rd_idx];
    end
  end

endmodule

// File: rtl/l2t_way_match.sv
module l2t_way_match #(
  parameter int TAG_W = 15,
  localparam int WORD_W = 2 * TAG_W + 1
) (
  input  logic [WORD_W-1:0]          word,
  input  logic [l2t_pkg::FLAG_W-1:0] flags,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output logic                       hit_way,
  output logic                       victim,
  output logic                       victim_dirty,
  output logic [TAG_W-1:0]           victim_tag
);

  logic [TAG_W-1:0] way_tag [2];
  logic [1:0]       match;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_tag[w] = word[w*TAG_W +: TAG_W];
    assign match[w]   = flags[w] && (way_tag[w] == req_tag);
  end

  assign hit          = |match;
  assign hit_way      = match[1];
  assign victim       = word[WORD_W-1];
  assign victim_dirty = flags[victim] && flags[2 + victim];
  assign victim_tag   = way_tag[victim];

endmodule

// File: rtl/l2t_beat_seq.sv
module l2t_beat_seq #(
  parameter int BEATS = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BEAT_W-1:0] crit,
  input  logic              adv,
  output logic [BEAT_W-1:0] sel,
  output logic              last
);

  logic [BEAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
      cnt <= '0;
    end else if (start) begin
      sel <= crit;
      cnt <= '0;
    end else if (adv) begin
      sel <= sel + 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == BEAT_W'(BEATS - 1));

endmodule

// File: rtl/l2_tag_ctrl.sv
module l2_tag_ctrl
  import l2t_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BUS_BYTES  = 8,
  parameter int SETS       = 4096,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int BEATS   = LINE_BYTES / BUS_BYTES,
  localparam int BEAT_W  = $clog2(BEATS),
  localparam int BANK_LO = $clog2(BUS_BYTES),
  localparam int WORD_W  = 2 * TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              bank_rd,
  output logic              bank_wr,
  output logic [BEAT_W-1:0] bank_sel,
  output logic [IDX_W-1:0]  bank_set,
  output logic              bank_way,
  input  logic              bank_ack,
  output logic              mem_req,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack
);

  l2t_state_e state;

  logic [IDX_W-1:0]  sweep;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [BEAT_W-1:0] req_crit;
  logic              req_we;
  logic              way_q;

  logic [WORD_W-1:0] tag_q;
  logic [FLAG_W-1:0] flag_q;
  logic              rd_en;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [WORD_W-1:0] wr_word;
  logic [FLAG_W-1:0] wr_flags;

  logic              hit;
  logic              hit_way;
  logic              victim;
  logic              victim_dirty;
  logic [TAG_W-1:0]  victim_tag;

  logic              beat_start;
  logic              beat_adv;
  logic              beat_last;

  logic              unused_byte_bits;
  logic [ADDR_W-1:0] fill_addr;

  assign unused_byte_bits = ^cpu_addr[BANK_LO-1:0];

  // Tag lookup is issued in the accepting cycle; the result is seen in ST_LOOK.
  assign rd_en = (state == ST_IDLE) && cpu_req;

  l2t_tag_store #(
    .SETS  (SETS),
    .TAG_W (TAG_W)
  ) i_store (
    .clk      (clk),
    .rd_en    (rd_en),
    .rd_idx   (cpu_addr[OFF_W +: IDX_W]),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_word  (wr_word),
    .wr_flags (wr_flags),
    .rd_word  (tag_q),
    .rd_flags (flag_q)
  );

  l2t_way_match #(
    .TAG_W (TAG_W)
  ) i_match (
    .word         (tag_q),
    .flags        (flag_q),
    .req_tag      (req_tag),
    .hit          (hit),
    .hit_way      (hit_way),
    .victim       (victim),
    .victim_dirty (victim_dirty),
    .victim_tag   (victim_tag)
  );

  assign beat_start = ((state == ST_LOOK) && hit) || ((state == ST_FILL) && mem_ack);
  assign beat_adv   = bank_rd && bank_ack;

  l2t_beat_seq #(
    .BEATS (BEATS)
  ) i_beats (
    .clk   (clk),
    .rst   (rst),
    .start (beat_start),
    .crit  (req_crit),
    .adv   (beat_adv),
    .sel   (bank_sel),
    .last  (beat_last)
  );

  assign fill_addr = {req_tag, req_idx, {OFF_W{1'b0}}};

  // Single tag-store write port: sweep, hit update or fill update.
  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = req_idx;
    wr_word  = tag_q;
    wr_flags = flag_q;
    case (state)
      ST_INIT: begin
        wr_en    = 1'b1;
        wr_idx   = sweep;
        wr_word  = '0;
        wr_flags = '0;
      end
      ST_LOOK: begin
        if (hit) begin
          wr_en               = 1'b1;
          wr_word[WORD_W-1]   = ~hit_way;
          if (req_we) wr_flags[2 + hit_way] = 1'b1;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          wr_en                            = 1'b1;
          wr_word[WORD_W-1]                = ~victim;
          wr_word[victim*TAG_W +: TAG_W]   = req_tag;
          wr_flags[victim]                 = 1'b1;
          wr_flags[2 + victim]             = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      sweep     <= '0;
      req_tag   <= '0;
      req_idx   <= '0;
      req_crit  <= '0;
      req_we    <= 1'b0;
      way_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      mem_req   <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      bank_rd   <= 1'b0;
      bank_wr   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_INIT: begin
          sweep <= sweep + 1'b1;
          if (sweep == IDX_W'(SETS - 1)) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (cpu_req) begin
            req_tag  <= cpu_addr[ADDR_W-1 -: TAG_W];
            req_idx  <= cpu_addr[OFF_W +: IDX_W];
            req_crit <= cpu_addr[BANK_LO +: BEAT_W];
            req_we   <= cpu_we;
            state    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          rsp_valid <= 1'b1;
          rsp_hit   <= hit;
          if (hit) begin
            way_q <= hit_way;
            if (req_we) begin
              bank_wr <= 1'b1;
              state   <= ST_WBEAT;
            end else begin
              bank_rd <= 1'b1;
              state   <= ST_STREAM;
            end
          end else if (req_we) begin
            state <= ST_IDLE;
          end else begin
            mem_req <= 1'b1;
            if (victim_dirty) begin
              mem_wr   <= 1'b1;
              mem_addr <= {victim_tag, req_idx, {OFF_W{1'b0}}};
              state    <= ST_WB;
            end else begin
              mem_wr   <= 1'b0;
              mem_addr <= fill_addr;
              state    <= ST_FILL;
            end
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            mem_wr   <= 1'b0;
            mem_addr <= fill_addr;
            state    <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            way_q   <= victim;
            bank_rd <= 1'b1;
            state   <= ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (bank_ack && beat_last) begin
            bank_rd <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        ST_WBEAT: begin
          if (bank_ack) begin
            bank_wr <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = (state == ST_IDLE);
  assign bank_set  = req_idx;
  assign bank_way  = way_q;

endmodule

// File: rtl/l2t_checker.sv
module l2t_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              rsp_valid,
  input logic              bank_rd,
  input logic              bank_wr,
  input logic [BEAT_W-1:0] bank_sel,
  input logic              bank_ack,
  input logic              mem_req,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (!mem_req && !bank_rd && !bank_wr)); // R10

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bank_rd && !bank_ack) |=> (bank_rd && $stable(bank_sel))); // R3

  AST_SEL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (bank_rd && bank_ack) |=> (!bank_rd || bank_sel == BEAT_W'($past(bank_sel) + 1'b1))); // R3

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wr))); // R7

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_wr && mem_ack) |=> (mem_req && !mem_wr)); // R7

  AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0)); // R5

  AST_ONE_BANK_OP: assert property (@(posedge clk) disable iff (rst)
    !(bank_rd && bank_wr)); // R8

endmodule

bind l2_tag_ctrl l2t_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .BEAT_W (BEAT_W)
) i_l2t_checker (
  .clk       (clk),
  .rst       (rst),
  .cpu_ready (cpu_ready),
  .rsp_valid (rsp_valid),
  .bank_rd   (bank_rd),
  .bank_wr   (bank_wr),
  .bank_sel  (bank_sel),
  .bank_ack  (bank_ack),
  .mem_req   (mem_req),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/test_l2_tag_ctrl.sv
module test_l2_tag_ctrl;

  localparam int SETS = 16;
  localparam int IW   = 4;
  localparam int TW   = 32 - 5 - IW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_ready, rsp_valid, rsp_hit;
  logic        bank_rd, bank_wr, bank_way;
  logic [1:0]  bank_sel;
  logic [IW-1:0] bank_set;
  logic        bank_ack = 1'b0;
  logic        mem_req, mem_wr;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  // Reference state derived from the requirements.
  logic [TW-1:0] m_tag [2][SETS];
  logic          m_val [2][SETS];
  logic          m_dty [2][SETS];
  logic          m_lru [SETS];
  logic          last_way;

  always #5 clk = ~clk;

  l2_tag_ctrl #(.SETS(SETS)) i_l2_tag_ctrl (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .bank_rd(bank_rd), .bank_wr(bank_wr), .bank_sel(bank_sel), .bank_set(bank_set),
    .bank_way(bank_way), .bank_ack(bank_ack), .mem_req(mem_req), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_ack(mem_ack)
  );

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < 2; w++) begin
        m_val[w][s] = 1'b0;
        m_dty[w][s] = 1'b0;
        m_tag[w][s] = '0;
      end
      m_lru[s] = 1'b0;
    end
  endtask

  // R1: reset, sweep length and idle outputs
  task automatic do_reset();
    int low_cycles;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !mem_req && !bank_rd && !bank_wr && !cpu_ready, "R1 idle in reset",
        {rsp_valid, mem_req, bank_rd, bank_wr, cpu_ready}, 0);
    rst = 1'b0;
    low_cycles = 0;
    while (!cpu_ready && low_cycles < 10 * SETS) begin
      low_cycles++;
      @(negedge clk);
    end
    chk(low_cycles == SETS, "R1 sweep length", low_cycles, SETS);
    model_clear();
  endtask

  task automatic access(input logic [31:0] a, input logic we);
    logic [IW-1:0] idx;
    logic [TW-1:0] tg;
    logic [1:0]    crit;
    logic          e_hit, e_way, e_wb, e_fill;
    logic [31:0]   e_wb_addr, e_fill_addr;
    int            e_nrd, e_nwr;
    int            nrsp, nrd, nwr, ncyc;
    logic          g_hit, wb_seen, fill_seen, order_bad, set_bad;
    logic [31:0]   wb_addr, fill_addr;
    logic [1:0]    rd_sel [4];
    logic          rd_way [4];
    logic [1:0]    wr_sel;
    logic          wr_way;

    idx  = a[8:5];
    tg   = a[31:9];
    crit = a[4:3];
    e_hit = 1'b0; e_way = 1'b0;
    for (int w = 0; w < 2; w++)
      if (m_val[w][idx] && m_tag[w][idx] == tg) begin e_hit = 1'b1; e_way = w[0]; end
    e_wb = 1'b0; e_fill = 1'b0; e_nrd = 0; e_nwr = 0;
    e_wb_addr = '0; e_fill_addr = {tg, idx, 5'b0};
    if (e_hit) begin
      if (we) begin e_nwr = 1; m_dty[e_way][idx] = 1'b1; end
      else e_nrd = 4;
      m_lru[idx] = ~e_way;
    end else if (!we) begin
      e_way = m_lru[idx];
      if (m_val[e_way][idx] && m_dty[e_way][idx]) begin
        e_wb = 1'b1;
        e_wb_addr = {m_tag[e_way][idx], idx, 5'b0};
      end
      e_fill = 1'b1;
      e_nrd = 4;
      m_tag[e_way][idx] = tg;
      m_val[e_way][idx] = 1'b1;
      m_dty[e_way][idx] = 1'b0;
      m_lru[idx] = ~e_way;
    end

    nrsp = 0; nrd = 0; nwr = 0; g_hit = 1'b0;
    wb_seen = 1'b0; fill_seen = 1'b0; order_bad = 1'b0; set_bad = 1'b0;
    wb_addr = '0; fill_addr = '0; wr_sel = '0; wr_way = 1'b0;
    for (int k = 0; k < 4; k++) begin rd_sel[k] = '0; rd_way[k] = 1'b0; end

    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    ncyc = 0;
    while (ncyc < 200) begin
      ncyc++;
      if (rsp_valid) begin nrsp++; g_hit = rsp_hit; end
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (mem_wr) begin
          wb_seen = 1'b1; wb_addr = mem_addr;
          if (fill_seen) order_bad = 1'b1;
        end else begin
          fill_seen = 1'b1; fill_addr = mem_addr;
        end
        mem_ack = 1'b1;
      end
      if (bank_ack) bank_ack = 1'b0;
      else if (bank_rd) begin
        if (nrd < 4) begin rd_sel[nrd] = bank_sel; rd_way[nrd] = bank_way; end
        if (bank_set != idx) set_bad = 1'b1;
        nrd++;
        bank_ack = 1'b1;
      end else if (bank_wr) begin
        wr_sel = bank_sel; wr_way = bank_way;
        if (bank_set != idx) set_bad = 1'b1;
        nwr++;
        bank_ack = 1'b1;
      end
      if (cpu_ready) break;
      @(negedge clk);
    end

    chk(ncyc < 200, "R10 transaction ends", ncyc, 0);
    chk(nrsp == 1, "R10 one response", nrsp, 1);
    chk(g_hit == e_hit, we ? "R9/R8 hit flag" : "R3/R5 hit flag", g_hit, e_hit);
    chk(wb_seen == e_wb, "R7 write-back present", wb_seen, e_wb);
    if (e_wb && wb_seen) chk(wb_addr == e_wb_addr, "R7 write-back address", wb_addr, e_wb_addr);
    chk(!order_bad, "R7 write-back before fill", order_bad, 0);
    chk(fill_seen == e_fill, we ? "R9 no fill" : "R5 fill present", fill_seen, e_fill);
    if (e_fill && fill_seen) chk(fill_addr == e_fill_addr, "R5 fill address", fill_addr, e_fill_addr);
    chk(nrd == e_nrd, "R3 read beat count", nrd, e_nrd);
    chk(nwr == e_nwr, "R8 write beat count", nwr, e_nwr);
    chk(!set_bad, "R2 bank set", set_bad, 0);
    if (e_nrd == 4 && nrd == 4) begin
      for (int k = 0; k < 4; k++) begin
        chk(rd_sel[k] == 2'(crit + k), "R3 beat order", rd_sel[k], 2'(crit + k));
        chk(rd_way[k] == e_way, e_hit ? "R4 hit way" : "R6 victim way", rd_way[k], e_way);
      end
      last_way = rd_way[0];
    end
    if (e_nwr == 1 && nwr == 1) begin
      chk(wr_sel == crit, "R8 write bank", wr_sel, crit);
      chk(wr_way == e_way, "R8 write way", wr_way, e_way);
    end
  endtask

  function automatic logic [TW-1:0] tag_pick(input int k);
    case (k % 3)
      0:       return 23'h000001;
      1:       return 23'h555555;
      default: return 23'h7ffffe;
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [TW-1:0] t, input int s, input int byteoff);
    return {t, 4'(s), 5'(byteoff)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    last_way = 1'b0;
    do_reset();

    // R6: first two misses in a set fill way 0 then way 1
    access(mk(tag_pick(0), 3, 16), 1'b0);
    chk(last_way == 1'b0, "R6 first fill way 0", last_way, 0);
    access(mk(tag_pick(1), 3, 8), 1'b0);
    chk(last_way == 1'b1, "R6 second fill way 1", last_way, 1);
    // R4: hit on way 0 makes way 1 the next victim
    access(mk(tag_pick(0), 3, 24), 1'b0);
    access(mk(tag_pick(2), 3, 0), 1'b0);
    chk(last_way == 1'b1, "R4 victim after hit", last_way, 1);

    // R8 then R7: dirty a line and force it out
    access(mk(tag_pick(2), 5, 0), 1'b0);
    access(mk(tag_pick(2), 5, 18), 1'b1);
    access(mk(tag_pick(0), 5, 0), 1'b0);
    access(mk(tag_pick(1), 5, 9), 1'b0);

    // R9: write miss does not allocate
    access(mk(tag_pick(1), 7, 0), 1'b1);
    access(mk(tag_pick(1), 7, 0), 1'b0);

    // Near-exhaustive sweep: every set, three competing tags, all banks
    for (int i = 0; i < 720; i++) begin
      int x;
      x = i * 37 + 11;
      access(mk(tag_pick(x / 16 + i / 5), x % 16, (i * 8 + i % 8) % 32), (i % 3) == 0);
    end

    // R1: a reset in use invalidates every line
    do_reset();
    for (int s = 0; s < SETS; s++) access(mk(tag_pick(s), s, 0), 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule